// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port with one transmitter and one receiver. A 2-bit mode input picks one of four framings. Mode 0 is a clocked shift-register link. The data pin is bidirectional and is split into an input, an output and an output enable. The transmit pin carries the shift clock. Modes 1, 2 and 3 are asynchronous UART framings. Mode 1 sends 8 data bits, and modes 2 and 3 send 9.

A write strobe with a byte starts a transmission. In modes 2 and 3 the ninth bit comes from a separate input. In mode 0 a reception starts on a pulse of `m0_rx_go`. In the asynchronous modes the receiver starts on its own when it detects a start bit. The baud source depends on the mode:

- Mode 0 uses a fixed divide of the system clock.
- Mode 2 uses an internal divide, selected by `slow2`.
- Modes 1 and 3 use `baud_tick`, an external strobe at 16 times the bit rate.

Completion is reported on two sticky flags, and software clears them with pulse inputs.

Top module: `serial_port_4m`

## Requirements
- R1: In mode 0 a write sends the 8 data bits, LSB first, on `dq_out` with `dq_oe` high and no start or stop bit. `txd` serves as the shift clock. Each bit cell lasts 12 clocks: `txd` is low for the first 6 clocks and high for the last 6. `dq_oe` is high only in mode 0.
- R2: In mode 0 a pulse on `m0_rx_go` (while `rx_done` is 0) generates 8 cells of shift clock on `txd`. `dq_in` is sampled at each rising edge of that clock. The bits form `rx_byte` LSB first, and `rx_done` is set at the end.
- R3: In mode 1 a write sends a 10-bit frame on `txd`: a start bit of 0, 8 data bits LSB first, and a stop bit of 1. Each bit lasts 16 `baud_tick` pulses.
- R4: In modes 2 and 3 a write sends an 11-bit frame: a start bit of 0, 8 data bits LSB first, the value of `tx_bit9`, and a stop bit of 1. In mode 3 a bit lasts 16 `baud_tick` pulses. In mode 2 a bit lasts 32 clocks when `slow2`=0 and 64 clocks when `slow2`=1.
- R5: In modes 1 to 3 the receiver takes 16 samples per bit and decides each bit by a majority of samples 7, 8 and 9. This makes a disturbance early in a bit harmless. The received byte goes to `rx_byte`. `rx_bit9` takes the ninth bit in modes 2 and 3, and takes the stop bit in mode 1.
- R6: A low pulse on `dq_in` that reads 1 at the middle of the start bit is dropped as a false start. `rx_done` stays 0, and a following frame is received correctly.
- R7: `tx_done` is set when the stop bit begins (modes 1 to 3), or after the eighth bit cell (mode 0). `rx_done` is set when a frame completes. Each flag stays set until its clear input (`tx_clr`, `rx_clr`) pulses.
- R8: A write while a transmission is in progress is ignored. The frame in flight is unchanged, and no second frame follows it.
- R9: In the asynchronous modes the transmitter and receiver work at the same time, without either disturbing the other.
- R10: After reset `txd` is 1, `dq_oe` is 0, and both flags are 0. While the transmitter is idle in modes 1 to 3, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Operating mode, 0 to 3 |
| slow2 | input | 1 | Mode 2 rate select: 0 gives 32 clocks per bit, 1 gives 64 |
| baud_tick | input | 1 | External strobe at 16 times the bit rate (modes 1 and 3) |
| wr_en | input | 1 | Write strobe; starts a transmission |
| wr_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in modes 2 and 3 |
| m0_rx_go | input | 1 | Starts a mode 0 reception |
| tx_clr | input | 1 | Clears `tx_done` |
| rx_clr | input | 1 | Clears `rx_done` |
| dq_in | input | 1 | Data pin input (serial receive data) |
| dq_out | output | 1 | Data pin output value (mode 0 transmit) |
| dq_oe | output | 1 | Data pin output enable |
| txd | output | 1 | Serial transmit data (modes 1 to 3) or shift clock (mode 0) |
| rx_byte | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Last received ninth bit, or the stop bit in mode 1 |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |

## Verification
In mode 3 the transmitter and receiver can both be mid-frame, and both advance on the same oversampling tick. The bench provokes this by writing a byte and, in the same cycle, starting an incoming frame of another value with its own ninth bit. It decodes `txd` at bit midpoints while it drives `dq_in`. The test passes when the outgoing frame matches its byte and ninth bit, the incoming byte and ninth bit land intact, and both flags end up set.

// File: rtl/serial_port_4m.sv
module serial_port_4m #(
  parameter int M0_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       slow2,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tx_bit9,
  input  logic       m0_rx_go,
  input  logic       tx_clr,
  input  logic       rx_clr,
  input  logic       dq_in,
  output logic       dq_out,
  output logic       dq_oe,
  output logic       txd,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       tx_done,
  output logic       rx_done
);
  localparam logic [3:0] M0_LAST = 4'(M0_DIV - 1);
  localparam logic [3:0] M0_HALF = 4'(M0_DIV / 2);

  logic [1:0]  rx_sync, pre, vote;
  logic [3:0]  m0_cnt, tx_ph, tx_left, rx_ph, rx_idx;
  logic [10:0] tx_sr;
  logic [7:0]  rx_sr;
  logic        tx_busy, rx_busy, b9_tmp;

  wire m0     = (mode == 2'd0);
  wire rx_s   = rx_sync[1];
  wire tick16 = (mode == 2'd2) ? (slow2 ? (pre == 2'd3) : pre[0]) : baud_tick;
  wire m0_act = m0 && (tx_busy || rx_busy);
  wire m0_end = m0_act && (m0_cnt == M0_LAST);
  wire sck    = !(m0_act && (m0_cnt < M0_HALF));
  wire tx_step = tx_busy && (m0 ? m0_end : (tick16 && tx_ph == 4'd15));
  wire maj    = (vote[0] & vote[1]) | (vote[0] & rx_s) | (vote[1] & rx_s);
  wire rx_go_ok = m0 && m0_rx_go && !tx_busy && !wr_en && !rx_busy && !rx_done;

  assign txd    = m0 ? sck : (tx_busy ? tx_sr[0] : 1'b1);
  assign dq_out = tx_sr[0];
  assign dq_oe  = m0 && tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync <= 2'b11;
      pre     <= '0;
      m0_cnt  <= '0;
    end else begin
      rx_sync <= {rx_sync[0], dq_in};
      pre     <= pre + 2'd1;
      if (!m0_act || m0_cnt == M0_LAST) m0_cnt <= '0;
      else m0_cnt <= m0_cnt + 4'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sr   <= '1;
      tx_left <= '0;
      tx_ph   <= '0;
      tx_done <= 1'b0;
    end else begin
      if (tx_clr) tx_done <= 1'b0;
      if (wr_en && !tx_busy && !(m0 && rx_busy)) begin
        tx_busy <= 1'b1;
        tx_ph   <= '0;
        if (m0) begin
          tx_sr   <= {3'b111, wr_data};
          tx_left <= 4'd8;
        end else begin
          tx_sr   <= {1'b1, (mode == 2'd1) ? 1'b1 : tx_bit9, wr_data, 1'b0};
          tx_left <= (mode == 2'd1) ? 4'd10 : 4'd11;
        end
      end else if (tx_busy) begin
        if (!m0 && tick16) tx_ph <= tx_ph + 4'd1;
        if (tx_step) begin
          tx_sr   <= {1'b1, tx_sr[10:1]};
          tx_left <= tx_left - 4'd1;
          if (!m0 && tx_left == 4'd2) tx_done <= 1'b1;
          if (tx_left == 4'd1) begin
            tx_busy <= 1'b0;
            if (m0) tx_done <= 1'b1;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_ph   <= '0;
      rx_idx  <= '0;
      rx_sr   <= '0;
      vote    <= '0;
      b9_tmp  <= 1'b0;
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (rx_clr) rx_done <= 1'b0;
      if (m0) begin
        if (!rx_busy) begin
          if (rx_go_ok) begin
            rx_busy <= 1'b1;
            rx_idx  <= '0;
          end
        end else begin
          if (m0_cnt == M0_HALF - 4'd1) rx_sr <= {rx_s, rx_sr[7:1]};
          if (m0_end) begin
            rx_idx <= rx_idx + 4'd1;
            if (rx_idx == 4'd7) begin
              rx_busy <= 1'b0;
              rx_byte <= rx_sr;
              rx_done <= 1'b1;
            end
          end
        end
      end else if (tick16) begin
        if (!rx_busy) begin
          if (!rx_s) begin
            rx_busy <= 1'b1;
            rx_ph   <= 4'd1;
            rx_idx  <= '0;
          end
        end else begin
          rx_ph <= rx_ph + 4'd1;
          if (rx_ph == 4'd7) vote[0] <= rx_s;
          if (rx_ph == 4'd8) vote[1] <= rx_s;
          if (rx_ph == 4'd15) rx_idx <= rx_idx + 4'd1;
          if (rx_ph == 4'd9) begin
            if (rx_idx == 4'd0) begin
              if (maj) rx_busy <= 1'b0;
            end else if (rx_idx <= 4'd8) begin
              rx_sr <= {maj, rx_sr[7:1]};
            end else if (rx_idx == 4'd9 && mode != 2'd1) begin
              b9_tmp <= maj;
            end else begin
              rx_busy <= 1'b0;
              rx_byte <= rx_sr;
              rx_bit9 <= (mode == 2'd1) ? maj : b9_tmp;
              rx_done <= 1'b1;
            end
          end
        end
      end
    end

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_clr |=> tx_done);
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_clr |=> rx_done);
  p_tx_set_from_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tx_busy));
  p_rx_set_from_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_busy));
  p_oe_only_m0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mode == 2'd0);
  p_sck_low_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 && $fell(txd)) |=> !txd);
  p_idle_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!m0 && !tx_busy) |-> txd);
endmodule

// File: tb/sim_serial_port_4m.sv
module sim_serial_port_4m;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'd0;
  logic slow2 = 0, baud_tick = 0, wr_en = 0, tx_bit9 = 0, m0_rx_go = 0;
  logic tx_clr = 0, rx_clr = 0, dq_in = 1;
  logic [7:0] wr_data = '0;
  logic dq_out, dq_oe, txd, rx_bit9, tx_done, rx_done;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, tcnt = 0;

  always #2 clk = ~clk;

  serial_port_4m u0 (.clk, .rst_n, .mode, .slow2, .baud_tick, .wr_en, .wr_data,
    .tx_bit9, .m0_rx_go, .tx_clr, .rx_clr, .dq_in, .dq_out, .dq_oe, .txd,
    .rx_byte, .rx_bit9, .tx_done, .rx_done);

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 3);
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_flags();
    @(negedge clk); tx_clr = 1; rx_clr = 1;
    @(negedge clk); tx_clr = 0; rx_clr = 0;
  endtask

  task automatic write(logic [7:0] d, logic b9);
    @(negedge clk); wr_data = d; tx_bit9 = b9; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic grab_tx(int bl, int n, output logic [10:0] bits, output logic ti_pre, output logic ti_stop);
    bits = '1; ti_pre = 0; ti_stop = 0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bl / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i == n - 2) ti_pre = tx_done;
      if (i == n - 1) ti_stop = tx_done;
      if (i < n - 1) repeat (bl) @(negedge clk);
    end
  endtask

  task automatic send_rx(int bl, int n, logic [10:0] bits, int gl);
    for (int i = 0; i < n; i++) begin
      if (i == gl) begin
        dq_in = ~bits[i]; repeat (6) @(negedge clk);
        dq_in = bits[i];  repeat (bl - 6) @(negedge clk);
      end else begin
        dq_in = bits[i]; repeat (bl) @(negedge clk);
      end
    end
    dq_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 txd idle", txd, 1);
    check("R10 oe idle", dq_oe, 0);
    check("R10 tx_done", tx_done, 0);
    check("R10 rx_done", rx_done, 0);
  endtask

  task automatic t_m0_tx();
    logic [7:0] got = '0; int low;
    mode = 2'd0; clr_flags();
    write(8'hA5, 0);
    for (int i = 0; i < 8; i++) begin
      while (txd !== 1'b0) @(negedge clk);
      low = 0;
      while (txd === 1'b0) begin low++; @(negedge clk); end
      if (i == 0 || i == 7) check("R1 sck low width", low, 6);
      got[i] = dq_out;
      if (i == 3) check("R1 oe during shift", dq_oe, 1);
    end
    repeat (8) @(negedge clk);
    check("R1 m0 byte", got, 8'hA5);
    check("R7 m0 tx_done", tx_done, 1);
    check("R1 oe released", dq_oe, 0);
  endtask

  task automatic t_m0_rx();
    logic [7:0] v = 8'h3C;
    mode = 2'd0; clr_flags();
    @(negedge clk); m0_rx_go = 1; @(negedge clk); m0_rx_go = 0;
    for (int i = 0; i < 8; i++) begin
      while (txd !== 1'b0) @(negedge clk);
      dq_in = v[i];
      while (txd === 1'b0) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    dq_in = 1;
    check("R2 m0 rx byte", rx_byte, 8'h3C);
    check("R2 m0 rx_done", rx_done, 1);
    repeat (30) @(negedge clk);
    check("R7 rx_done held", rx_done, 1);
    clr_flags();
    check("R7 rx_done cleared", rx_done, 0);
    check("R7 tx_done cleared", tx_done, 0);
  endtask

  task automatic t_async_tx(logic [1:0] m, logic s2, int bl, logic [7:0] d, logic b9);
    logic [10:0] bits, exp; logic tp, ts; int n;
    mode = m; slow2 = s2; clr_flags();
    n = (m == 2'd1) ? 10 : 11;
    exp = (m == 2'd1) ? {2'b11, d, 1'b0} : {1'b1, b9, d, 1'b0};
    write(d, b9);
    grab_tx(bl, n, bits, tp, ts);
    if (m == 2'd1) check("R3 mode1 frame", bits, exp);
    else check("R4 9-bit frame", bits, exp);
    check("R7 tx_done not before stop", tp, 0);
    check("R7 tx_done at stop", ts, 1);
    repeat (bl) @(negedge clk);
  endtask

  task automatic t_async_rx(logic [1:0] m, logic s2, int bl, logic [7:0] d, logic b9, int gl);
    int n;
    mode = m; slow2 = s2; clr_flags();
    n = (m == 2'd1) ? 10 : 11;
    send_rx(bl, n, (m == 2'd1) ? {2'b11, d, 1'b0} : {1'b1, b9, d, 1'b0}, gl);
    check("R5 rx byte", rx_byte, d);
    check("R5 rx ninth", rx_bit9, (m == 2'd1) ? 1'b1 : b9);
    check("R5 rx_done", rx_done, 1);
  endtask

  task automatic t_false_start();
    mode = 2'd1; clr_flags();
    @(negedge clk); dq_in = 0; repeat (16) @(negedge clk); dq_in = 1;
    repeat (160) @(negedge clk);
    check("R6 no rx_done on glitch", rx_done, 0);
    t_async_rx(2'd1, 0, 64, 8'h44, 0, -1);
  endtask

  task automatic t_busy_write();
    logic [10:0] bits; logic tp, ts; int hi = 0;
    mode = 2'd1; clr_flags();
    write(8'h11, 0);
    fork
      grab_tx(64, 10, bits, tp, ts);
      begin repeat (100) @(negedge clk); write(8'hEE, 0); end
    join
    check("R8 frame kept", bits, {2'b11, 8'h11, 1'b0});
    repeat (40) @(negedge clk);
    for (int i = 0; i < 250; i++) begin @(negedge clk); if (txd === 1'b1) hi++; end
    check("R8 no second frame", hi, 250);
  endtask

  task automatic t_duplex();
    logic [10:0] bits; logic tp, ts;
    mode = 2'd3; clr_flags();
    fork
      begin write(8'h69, 1); grab_tx(64, 11, bits, tp, ts); end
      begin @(negedge clk); send_rx(64, 11, {1'b1, 1'b0, 8'hB2, 1'b0}, -1); end
    join
    repeat (70) @(negedge clk);
    check("R9 duplex tx frame", bits, {1'b1, 1'b1, 8'h69, 1'b0});
    check("R9 duplex rx byte", rx_byte, 8'hB2);
    check("R9 duplex rx ninth", rx_bit9, 0);
    check("R9 both flags", {tx_done, rx_done}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_m0_tx();
    t_m0_rx();
    t_async_tx(2'd1, 0, 64, 8'h5A, 0);
    t_async_tx(2'd3, 0, 64, 8'h96, 1);
    t_async_tx(2'd2, 0, 32, 8'h3E, 0);
    t_async_tx(2'd2, 1, 64, 8'hC1, 1);
    t_async_rx(2'd1, 0, 64, 8'hC3, 0, -1);
    t_async_rx(2'd3, 0, 64, 8'h81, 0, 3);
    t_async_rx(2'd2, 0, 32, 8'h7E, 1, -1);
    t_async_rx(2'd2, 1, 64, 8'h0F, 1, 5);
    t_false_start();
    t_busy_write();
    t_duplex();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule